// File: doc/BRIEF.md
# Latched Programmable Tap Delay Line

This block delays a one-bit input stream by a programmable number of clock cycles. A ten-bit step count picks a tap on a shift register of 1025 stages. A registered output stage adds a fixed two-cycle floor to every setting. A single step count of zero therefore gives two cycles of latency, and a count of N gives N + 2 cycles.

The step count, together with an eleventh chaining bit, passes through a load/hold stage. While the load control is low the stage is transparent and the delay follows the select inputs at once. When the load control goes high, the word sampled at the last clock edge with the control low is frozen. The chaining bit drives a true/inverted pair of outputs, so that a controller can route a signal through several units in series.

Two override inputs force the shortest or the longest delay, and the shortest wins when both are set. An output-disable input clamps the delayed output low.

Top module: `prog_tap_delay`

## Requirements
- R1: After a clock edge with `rst_n` low, `dout` is 0, every stage of the delay chain holds 0 and the held select word is 0. With `load_en` high and no override, `casc` is then 0 and `casc_n` is 1.
- R2: With no override active, `dout` after clock edge n equals the `din` value sampled at edge n-1-k, where k is `sel_i[9:0]` read as an unsigned step count (bit 0 least significant). The total delay is k + 2 cycles.
- R3: While `load_en` is low, the select word in effect is the live `sel_i`, with no clock delay on either the tap choice or `casc`.
- R4: While `load_en` is high, the select word in effect is the `sel_i` value sampled at the last rising clock edge at which `load_en` was low. Later changes of `sel_i` have no effect on `dout` or `casc` until `load_en` returns low.
- R5: With no override, `casc` equals bit 10 of the select word in effect, and `casc_n` is always the complement of `casc`.
- R6: When `set_min` is high, the step count is 0 and `casc` is 0, whatever `set_max`, `sel_i` and the held word are.
- R7: When `set_max` is high and `set_min` is low, the step count is 1024, one more than the all-ones code, and `casc` is 1.
- R8: When `out_dis` is high at a clock edge, `dout` is 0 after that edge, whatever `din` and the tap in use.
- R9: An override leaves the held select word unchanged. When the override is released with `load_en` still high, the held delay and chaining bit return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay step is one cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data stream to be delayed |
| sel_i | input | 11 | Bits 9..0 step count, bit 10 chaining bit |
| load_en | input | 1 | Low: select transparent; high: select held |
| set_min | input | 1 | Force step count 0 and `casc` low (highest priority) |
| set_max | input | 1 | Force step count 1024 and `casc` high |
| out_dis | input | 1 | High clamps `dout` low from the next edge |
| dout | output | 1 | Delayed data |
| casc | output | 1 | Chaining bit, true polarity |
| casc_n | output | 1 | Chaining bit, inverted polarity |

## Verification
A corrupted stage of the chain shows on `dout` only once the tap in use reaches that stage. For this reason the bench runs settings from zero up to the full 1024-step length and compares every cycle, so that a wrong bit surfaces within one delay span. A held word that captured the wrong edge, or a priority mix-up, shows on `casc` and `casc_n` in the same cycle. The same fault shows on `dout` after the new delay, the moment `sel_i` moves while held or an override toggles.

// File: rtl/prog_tap_delay_pkg.sv
// Package: shared constants and the override decoding function.
// Assumes: the step field is the low part of the select word and the
// chaining bit sits directly above it.
package prog_tap_delay_pkg;

    // Resolve the tap count from the overrides and the select step field.
    function automatic logic [15:0] resolve_tap(
        input logic        force_min,
        input logic        force_max,
        input logic [15:0] step,
        input logic [15:0] top_tap
    );
        if (force_min)      return 16'd0;
        else if (force_max) return top_tap;
        else                return step;
    endfunction

endpackage

// File: rtl/ptd_select_latch.sv
// Module: ptd_select_latch
// Holds the select word. While load_en is low the output follows sel_i
// directly and the register tracks it on every edge. While load_en is
// high the output is the word captured at the last edge with load_en low.
// Assumes: rst_n is synchronous; after reset the held word is zero.
module ptd_select_latch #(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] sel_i,
    output logic [WORD_W-1:0] sel_o
);

    logic [WORD_W-1:0] held_q;

    // Track the live word while loading; freeze it while holding.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= '0;
        else if (!load_en) held_q <= sel_i;
    end

    // Transparent path while loading, frozen copy while holding.
    always_comb sel_o = load_en ? held_q : sel_i;

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_en) && load_en) |-> (sel_o == $past(sel_o)));

endmodule

// File: rtl/ptd_override.sv
// Module: ptd_override
// Applies the minimum and maximum overrides to the select word and forms
// the tap count and the complementary chaining outputs.
// Assumes: set_min outranks set_max; both outrank every select bit.
module ptd_override
    import prog_tap_delay_pkg::*;
#(
    parameter int STEP_W = 10,
    localparam int TAP_W = STEP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_min,
    input  logic             set_max,
    input  logic [STEP_W:0]  sel_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             casc_o,
    output logic             casc_n_o
);

    localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(1) << STEP_W;

    logic [15:0] tap_wide;

    // Priority pick of the tap count.
    always_comb begin
        tap_wide = resolve_tap(set_min, set_max,
                               16'({1'b0, sel_i[STEP_W-1:0]}), 16'(TOP_TAP));
        tap_o    = tap_wide[TAP_W-1:0];
    end

    // True chaining output: min forces low, max forces high.
    always_comb casc_o = !set_min && (set_max || sel_i[STEP_W]);

    // Inverted chaining output, formed as its own sum of terms.
    always_comb casc_n_o = set_min || (!set_max && !sel_i[STEP_W]);

    assert_casc_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        casc_o != casc_n_o);

    assert_min_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_min |-> (tap_o == '0 && !casc_o));

    assert_max_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_max && !set_min) |-> (tap_o == TOP_TAP && casc_o));

endmodule

// File: rtl/ptd_tap_chain.sv
// Module: ptd_tap_chain
// Shift register of MAX_TAP+1 stages. Stage k holds din from k+1 edges
// ago. A registered read picks stage tap_i, or zero when out_dis is set.
// Assumes: tap_i never exceeds MAX_TAP.
module ptd_tap_chain #(
    parameter int MAX_TAP = 1024,
    localparam int TAP_W  = $clog2(MAX_TAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [TAP_W-1:0] tap_i,
    input  logic             out_dis,
    output logic             q_o
);

    logic [MAX_TAP:0] stage_q;

    // Advance the chain by one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[MAX_TAP-1:0], din};
    end

    // Registered tap read with the output clamp.
    always_ff @(posedge clk) begin
        if (!rst_n || out_dis) q_o <= 1'b0;
        else                   q_o <= stage_q[tap_i];
    end

endmodule

// File: rtl/prog_tap_delay.sv
// Module: prog_tap_delay (top)
// Programmable delay of a one-bit stream: select hold stage, override
// priority, tap chain with registered read, complementary chaining outputs.
// Assumes: one delay step equals one clock; fixed floor of two cycles.
module prog_tap_delay #(
    parameter int STEP_W   = 10,
    localparam int WORD_W  = STEP_W + 1,
    localparam int MAX_TAP = 1 << STEP_W,
    localparam int TAP_W   = STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [WORD_W-1:0] sel_i,
    input  logic              load_en,
    input  logic              set_min,
    input  logic              set_max,
    input  logic              out_dis,
    output logic              dout,
    output logic              casc,
    output logic              casc_n
);

    logic [WORD_W-1:0] sel_eff;
    logic [TAP_W-1:0]  tap;
    logic [1:0]        run_age;

    ptd_select_latch #(.WORD_W(WORD_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .sel_i   (sel_i),
        .sel_o   (sel_eff)
    );

    ptd_override #(.STEP_W(STEP_W)) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_min  (set_min),
        .set_max  (set_max),
        .sel_i    (sel_eff),
        .tap_o    (tap),
        .casc_o   (casc),
        .casc_n_o (casc_n)
    );

    ptd_tap_chain #(.MAX_TAP(MAX_TAP)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .tap_i   (tap),
        .out_dis (out_dis),
        .q_o     (dout)
    );

    // Edges since reset, saturating at two; used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_age <= 2'd0;
        else if (run_age != 2'd2)  run_age <= run_age + 2'd1;
    end

    assert_min_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_age == 2'd2 && $past(set_min) && !$past(out_dis))
            |-> (dout == $past(din, 2)));

    assert_out_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_dis) |-> !dout);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !dout);

endmodule

// File: tb/test_prog_tap_delay.sv
`timescale 1ns/1ps
module test_prog_tap_delay;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        din = 1'b0;
    logic [10:0] sel_i = '0;
    logic        load_en = 1'b0;
    logic        set_min = 1'b0;
    logic        set_max = 1'b0;
    logic        out_dis = 1'b0;
    logic        dout, casc, casc_n;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    bit    hist [0:16383];
    int    edge_n = 0;
    logic [10:0] m_held = '0;
    bit    exp_q = 0;
    bit    exp_casc = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    prog_tap_delay i_prog_tap_delay (
        .clk(clk), .rst_n(rst_n), .din(din), .sel_i(sel_i), .load_en(load_en),
        .set_min(set_min), .set_max(set_max), .out_dis(out_dis),
        .dout(dout), .casc(casc), .casc_n(casc_n)
    );

    always #5 clk = ~clk;

    function automatic bit past_din(int idx);
        if (idx < 0) return 1'b0;
        return hist[idx];
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, edge_n, act, exp);
        end
    endtask

    // Behavioural model, compared one time unit after every rising edge.
    always @(posedge clk) begin
        logic [10:0] eff;
        int tap;
        if (!rst_n) begin
            m_held = '0;
            exp_q  = 0;
            hist[edge_n] = 0;
        end else begin
            eff = load_en ? m_held : sel_i;
            tap = set_min ? 0 : (set_max ? 1024 : int'(eff[9:0]));
            exp_q = out_dis ? 1'b0 : past_din(edge_n - 1 - tap);
            hist[edge_n] = din;
            if (!load_en) m_held = sel_i;
        end
        edge_n++;
        #1;
        eff = load_en ? m_held : sel_i;
        exp_casc = set_min ? 1'b0 : (set_max ? 1'b1 : eff[10]);
        if (!done) begin
            chk(cur_req, "dout", dout, exp_q);
            chk(cur_req, "casc", casc, exp_casc);
            chk("R5", "casc_n", casc_n, !exp_casc);
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            din = lfsr[0];
        end
    endtask

    initial begin
        // R1: reset, then held word zero with load_en high
        rst_n = 1'b0; load_en = 1'b1; sel_i = 11'h7FF;
        run(3);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1", "dout after reset", dout, 1'b0);
        chk("R1", "casc after reset", casc, 1'b0);
        chk("R1", "casc_n after reset", casc_n, 1'b1);
        // R2: several tap counts with transparent select (R3)
        @(negedge clk); load_en = 1'b0;
        cur_req = "R2";
        foreach (sel_i[i]) ;
        sel_i = 11'd0;    run(40);
        sel_i = 11'd1;    run(40);
        sel_i = 11'd5;    run(60);
        sel_i = 11'd37;   run(100);
        sel_i = 11'd300;  run(360);
        sel_i = 11'd1023; run(1080);
        // R3: live changes follow at once, chaining bit too (R5)
        cur_req = "R3";
        for (int k = 0; k < 8; k++) begin
            sel_i = 11'(k * 133 + 1024 * (k % 2));
            run(25);
        end
        // R4: capture then ignore later select changes
        cur_req = "R4";
        sel_i = 11'h40C; run(5);
        @(negedge clk); load_en = 1'b1; sel_i = 11'd200;
        run(30);
        sel_i = 11'd3; run(30);
        chk("R4", "casc held from bit 10", casc, 1'b1);
        // R9: overrides leave the held word in place
        cur_req = "R6";
        set_min = 1'b1; set_max = 1'b1; run(30);
        set_max = 1'b0; run(20);
        cur_req = "R9";
        set_min = 1'b0; run(30);
        chk("R9", "held chaining bit back", casc, 1'b1);
        // R7: longest delay, one beyond all ones
        cur_req = "R7";
        set_max = 1'b1; run(1090);
        cur_req = "R9";
        set_max = 1'b0; run(40);
        // R3: release hold, live word takes effect
        cur_req = "R3";
        @(negedge clk); load_en = 1'b0; sel_i = 11'd4;
        run(30);
        // R8: output clamp pulses
        cur_req = "R8";
        din = 1'b1; sel_i = 11'd0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); din = 1'b1; out_dis = 1'b1;
            @(negedge clk); din = 1'b1; out_dis = 1'b0;
            @(negedge clk); din = 1'b1;
        end
        @(negedge clk); out_dis = 1'b1; run(20);
        chk("R8", "dout clamped", dout, 1'b0);
        out_dis = 1'b0; run(20);
        // R1: reset again mid-stream
        cur_req = "R1";
        sel_i = 11'd9; run(20);
        @(negedge clk); rst_n = 1'b0; load_en = 1'b1;
        run(2);
        @(negedge clk); rst_n = 1'b1;
        run(30);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule